// File: doc/BRIEF.md
# Load/Store Multiple Address Sequencer

This block drives the address side of a block transfer that moves several registers to or from memory in one operation. It is started with a base address, a 16-bit register selection mask and a 2-bit addressing mode. It then walks through the selected registers, presenting one register index and one word address per transfer. Each transfer waits for a ready handshake from the memory side before the next one is presented.

Before the first transfer, the sequencer counts the selected registers so that all four addressing modes lay the registers out in ascending order at ascending word addresses. When the last transfer is accepted, it reports completion together with the updated base value, which is enabled only when write-back was requested. It also reports whether the program counter is among the selected registers. When a load fills the program counter, it returns the loaded word with bit 0 cleared as the new program counter and passes bit 0 on as the instruction-set select. A load that fills the program counter with the status-restore flag set also raises a status-restore pulse.

Top module: `lsm_addr_seq`

## Requirements
- R1: The number of accepted transfers equals the number of set bits in the captured mask, and register indices are presented in strictly ascending order. `xfer_valid_o` and `busy_o` are high from the cycle after an accepted start until the last transfer is accepted.
- R2: Mode 2'b00 (ascend, address after) presents its first transfer at the base address.
- R3: Mode 2'b01 (ascend, address before) presents its first transfer at base + 4.
- R4: Mode 2'b10 (descend, address after) presents its first transfer at base − 4·n + 4, where n is the mask's set-bit count, modulo 2^32.
- R5: Mode 2'b11 (descend, address before) presents its first transfer at base − 4·n, modulo 2^32.
- R6: Each transfer after the first is presented at the previous transfer's address + 4.
- R7: `done_o` pulses for one cycle in the cycle after the last transfer is accepted. In that cycle `wb_addr_o` carries base + 4·n for modes 2'b00/2'b01 and base − 4·n for modes 2'b10/2'b11, and `wb_en_o` is high only if `wback_i` was high at start.
- R8: `pc_in_list_o` equals mask bit 15 of the most recently accepted start, from the cycle after that start onward.
- R9: When the transfer of index 15 is accepted during a load (`load_i` high at start), `pc_load_o` pulses in the next cycle. In that cycle `pc_value_o` is `rdata_i` sampled at acceptance with bit 0 cleared, and `isa_sel_o` is that sampled bit 0. A store never raises `pc_load_o`.
- R10: `restore_status_o` pulses together with `done_o` only when the operation was a load with `sbit_i` high and mask bit 15 set.
- R11: An empty mask gives `done_o` in the cycle after start, with no transfer and with `wb_addr_o` equal to the base.
- R12: While `xfer_valid_o` is high and `xfer_ready_i` is low, the presented index and address hold unchanged in the next cycle.
- R13: `start_i` is ignored while `busy_o` is high: the running operation keeps its mask, addresses and transfer count.
- R14: After reset, `busy_o`, `xfer_valid_o`, `done_o`, `wb_en_o`, `pc_load_o`, `restore_status_o` and `pc_in_list_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register selection mask, bit i selects register i, bit 15 is the program counter |
| mode_i | input | 2 | Addressing mode (00 ascend-after, 01 ascend-before, 10 descend-after, 11 descend-before) |
| wback_i | input | 1 | Request base write-back |
| load_i | input | 1 | 1 = load operation, 0 = store |
| sbit_i | input | 1 | Status-restore request |
| xfer_ready_i | input | 1 | Memory side accepts the presented transfer |
| rdata_i | input | 32 | Loaded word, sampled when a transfer is accepted |
| busy_o | output | 1 | Operation in progress |
| xfer_valid_o | output | 1 | Transfer presented |
| xfer_idx_o | output | 4 | Register index of the presented transfer |
| xfer_addr_o | output | 32 | Word address of the presented transfer |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base write-back enable, with done |
| wb_addr_o | output | 32 | Updated base value, with done |
| pc_in_list_o | output | 1 | Program counter is in the captured mask |
| pc_load_o | output | 1 | One-cycle pulse: program counter loaded |
| pc_value_o | output | 32 | New program counter, bit 0 cleared |
| isa_sel_o | output | 1 | Instruction-set select taken from loaded bit 0 |
| restore_status_o | output | 1 | One-cycle status-restore pulse |

## Verification
A wrong remaining-mask or address register shows at the ports on the very next presented transfer: an out-of-order index, an address that does not step by 4, or a transfer count that differs from the popcount, which the bench sees when the operation's done pulse arrives. A wrong start-address or write-back computation is visible in the first transfer and in the done cycle. A lost handshake stall shows as an index or address that changes while ready was low. The behavioural reference model is compared with every output on every cycle, so any divergence surfaces in the cycle it occurs.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        MODE_ASC_AFTER  = 2'b00,
        MODE_ASC_BEFORE = 2'b01,
        MODE_DSC_AFTER  = 2'b10,
        MODE_DSC_BEFORE = 2'b11
    } lsm_mode_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } lsm_phase_e;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int W     = 16,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     mask_i,
    output logic [CNT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CNT_W'(mask_i[i]);
        end
    end
endmodule

// File: rtl/lsm_lowest_bit.sv
module lsm_lowest_bit #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     mask_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [W-1:0]     rest_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign rest_o = mask_i & (mask_i - W'(1));
endmodule

// File: rtl/lsm_start_calc.sv
module lsm_start_calc
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  lsm_mode_e         mode_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] wb_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] span;

    assign span = ADDR_W'(count_i) * STEP_V;

    always_comb begin
        unique case (mode_i)
            MODE_ASC_AFTER:  first_o = base_i;
            MODE_ASC_BEFORE: first_o = base_i + STEP_V;
            MODE_DSC_AFTER:  first_o = base_i - span + STEP_V;
            default:         first_o = base_i - span;
        endcase
        if (mode_i == MODE_DSC_AFTER || mode_i == MODE_DSC_BEFORE) begin
            wb_o = base_i - span;
        end else begin
            wb_o = base_i + span;
        end
    end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16,
    parameter int STEP   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [LIST_W-1:0]         list_i,
    input  logic [1:0]                mode_i,
    input  logic                      wback_i,
    input  logic                      load_i,
    input  logic                      sbit_i,
    input  logic                      xfer_ready_i,
    input  logic [ADDR_W-1:0]         rdata_i,
    output logic                      busy_o,
    output logic                      xfer_valid_o,
    output logic [$clog2(LIST_W)-1:0] xfer_idx_o,
    output logic [ADDR_W-1:0]         xfer_addr_o,
    output logic                      done_o,
    output logic                      wb_en_o,
    output logic [ADDR_W-1:0]         wb_addr_o,
    output logic                      pc_in_list_o,
    output logic                      pc_load_o,
    output logic [ADDR_W-1:0]         pc_value_o,
    output logic                      isa_sel_o,
    output logic                      restore_status_o
);
    localparam int IDX_W  = $clog2(LIST_W);
    localparam int CNT_W  = $clog2(LIST_W + 1);
    localparam int PC_IDX = LIST_W - 1;

    typedef struct packed {
        lsm_phase_e          phase;
        logic [LIST_W-1:0]   rem;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   wb_val;
        logic                wb_req;
        logic                is_load;
        logic                restore;
        logic                pc_flag;
        logic                done;
        logic                wb_en;
        logic [ADDR_W-1:0]   wb_addr;
        logic                pc_load;
        logic [ADDR_W-1:0]   pc_val;
        logic                isa;
        logic                rstat;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [CNT_W-1:0]  sel_count;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] wb_calc;
    logic [IDX_W-1:0]  cur_idx;
    logic [LIST_W-1:0] rem_rest;

    lsm_popcount #(.W(LIST_W), .CNT_W(CNT_W)) u_count (
        .mask_i  (list_i),
        .count_o (sel_count)
    );

    lsm_start_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_calc (
        .base_i  (base_i),
        .mode_i  (lsm_mode_e'(mode_i)),
        .count_i (sel_count),
        .first_o (first_addr),
        .wb_o    (wb_calc)
    );

    lsm_lowest_bit #(.W(LIST_W), .IDX_W(IDX_W)) u_pick (
        .mask_i (state_q.rem),
        .idx_o  (cur_idx),
        .rest_o (rem_rest)
    );

    always_comb begin
        state_d         = state_q;
        state_d.done    = 1'b0;
        state_d.wb_en   = 1'b0;
        state_d.pc_load = 1'b0;
        state_d.rstat   = 1'b0;

        unique case (state_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    state_d.pc_flag = list_i[PC_IDX];
                    state_d.is_load = load_i;
                    state_d.wb_req  = wback_i;
                    state_d.wb_val  = wb_calc;
                    state_d.restore = load_i & sbit_i & list_i[PC_IDX];
                    if (list_i == '0) begin
                        state_d.done    = 1'b1;
                        state_d.wb_en   = wback_i;
                        state_d.wb_addr = wb_calc;
                    end else begin
                        state_d.phase = PH_RUN;
                        state_d.rem   = list_i;
                        state_d.addr  = first_addr;
                    end
                end
            end
            default: begin
                if (xfer_ready_i) begin
                    state_d.rem  = rem_rest;
                    state_d.addr = state_q.addr + ADDR_W'(STEP);
                    if (state_q.is_load && cur_idx == IDX_W'(PC_IDX)) begin
                        state_d.pc_load = 1'b1;
                        state_d.pc_val  = {rdata_i[ADDR_W-1:1], 1'b0};
                        state_d.isa     = rdata_i[0];
                    end
                    if (rem_rest == '0) begin
                        state_d.phase   = PH_IDLE;
                        state_d.done    = 1'b1;
                        state_d.wb_en   = state_q.wb_req;
                        state_d.wb_addr = state_q.wb_val;
                        state_d.rstat   = state_q.restore;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o           = (state_q.phase == PH_RUN);
    assign xfer_valid_o     = (state_q.phase == PH_RUN);
    assign xfer_idx_o       = cur_idx;
    assign xfer_addr_o      = state_q.addr;
    assign done_o           = state_q.done;
    assign wb_en_o          = state_q.wb_en;
    assign wb_addr_o        = state_q.wb_addr;
    assign pc_in_list_o     = state_q.pc_flag;
    assign pc_load_o        = state_q.pc_load;
    assign pc_value_o       = state_q.pc_val;
    assign isa_sel_o        = state_q.isa;
    assign restore_status_o = state_q.rstat;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16,
    parameter int STEP   = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy_o,
    input logic                      xfer_valid_o,
    input logic                      xfer_ready_i,
    input logic [$clog2(LIST_W)-1:0] xfer_idx_o,
    input logic [ADDR_W-1:0]         xfer_addr_o,
    input logic                      done_o,
    input logic                      wb_en_o,
    input logic                      pc_load_o,
    input logic                      restore_status_o
);
    localparam int IDX_W = $clog2(LIST_W);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !xfer_ready_i) |=> (xfer_valid_o && $stable(xfer_idx_o) && $stable(xfer_addr_o))); // R12

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xfer_valid_o && xfer_ready_i) && xfer_valid_o) |-> (xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(STEP))); // R6

    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xfer_valid_o && xfer_ready_i) && xfer_valid_o) |-> (xfer_idx_o > $past(xfer_idx_o))); // R1

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !xfer_valid_o)); // R11

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o); // R7

    AST_PC_AFTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> $past(xfer_valid_o && xfer_ready_i && xfer_idx_o == IDX_W'(LIST_W - 1))); // R9

    AST_RESTORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_status_o |-> (done_o && pc_load_o)); // R10
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .LIST_W(LIST_W), .STEP(STEP)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .busy_o           (busy_o),
    .xfer_valid_o     (xfer_valid_o),
    .xfer_ready_i     (xfer_ready_i),
    .xfer_idx_o       (xfer_idx_o),
    .xfer_addr_o      (xfer_addr_o),
    .done_o           (done_o),
    .wb_en_o          (wb_en_o),
    .pc_load_o        (pc_load_o),
    .restore_status_o (restore_status_o)
);

// File: tb/lsm_addr_seq_tb_top.sv
module lsm_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] list_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wback_i = 1'b0, load_i = 1'b0, sbit_i = 1'b0;
    logic        xfer_ready_i = 1'b1;
    logic [31:0] rdata_i = '0;
    logic        busy_o, xfer_valid_o, done_o, wb_en_o, pc_in_list_o;
    logic        pc_load_o, isa_sel_o, restore_status_o;
    logic [3:0]  xfer_idx_o;
    logic [31:0] xfer_addr_o, wb_addr_o, pc_value_o;

    lsm_addr_seq dut_i (.*);

    always #2 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    bit rdy_rand = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // behavioural reference model
    int          q_idx[$];
    logic [31:0] q_addr[$];
    bit          m_busy, m_done, m_wb_en, m_pc_load, m_isa, m_rst, m_pcflag;
    bit          m_load, m_w, m_s, m_p, m_first, m_stalled;
    logic [1:0]  m_mode;
    logic [31:0] m_wb_addr, m_wbv, m_pc;
    int          xfer_cnt;

    always @(posedge clk) begin
        m_done = 0; m_wb_en = 0; m_pc_load = 0; m_rst = 0; m_first = 0; m_stalled = 0;
        if (!rst_n) begin
            m_busy = 0; m_pcflag = 0; m_pc = 0; m_isa = 0; m_wb_addr = 0;
            q_idx.delete(); q_addr.delete();
        end else if (m_busy) begin
            if (xfer_ready_i) begin
                int ix;
                ix = q_idx.pop_front();
                void'(q_addr.pop_front());
                xfer_cnt++;
                if (ix == 15 && m_load) begin
                    m_pc_load = 1; m_pc = rdata_i & 32'hFFFF_FFFE; m_isa = rdata_i[0];
                end
                if (q_idx.size() == 0) begin
                    m_busy = 0; m_done = 1; m_wb_en = m_w; m_wb_addr = m_wbv;
                    m_rst = m_load && m_s && m_p;
                end
            end else begin
                m_stalled = 1;
            end
        end else if (start_i) begin
            int n;
            logic [31:0] a;
            n = $countones(list_i);
            m_load = load_i; m_w = wback_i; m_s = sbit_i; m_p = list_i[15];
            m_pcflag = list_i[15]; m_mode = mode_i;
            m_wbv = mode_i[1] ? base_i - 32'(4 * n) : base_i + 32'(4 * n);
            case (mode_i)
                2'b00: a = base_i;
                2'b01: a = base_i + 32'd4;
                2'b10: a = base_i - 32'(4 * n) + 32'd4;
                default: a = base_i - 32'(4 * n);
            endcase
            for (int i = 0; i < 16; i++) begin
                if (list_i[i]) begin
                    q_idx.push_back(i); q_addr.push_back(a); a = a + 32'd4;
                end
            end
            if (n == 0) begin
                m_done = 1; m_wb_en = wback_i; m_wb_addr = base_i;
            end else begin
                m_busy = 1; m_first = 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            string atag;
            chk(busy_o == m_busy, "R1", "busy", busy_o, m_busy);
            chk(xfer_valid_o == m_busy, "R1", "valid", xfer_valid_o, m_busy);
            if (m_busy && xfer_valid_o) begin
                chk(xfer_idx_o == 4'(q_idx[0]), "R1", "index", xfer_idx_o, q_idx[0]);
                if (m_first) begin
                    case (m_mode)
                        2'b00: atag = "R2";
                        2'b01: atag = "R3";
                        2'b10: atag = "R4";
                        default: atag = "R5";
                    endcase
                end else if (m_stalled) atag = "R12";
                else atag = "R6";
                chk(xfer_addr_o == q_addr[0], atag, "address", xfer_addr_o, q_addr[0]);
            end
            chk(done_o == m_done, "R11", "done", done_o, m_done);
            chk(wb_en_o == m_wb_en, "R7", "wb_en", wb_en_o, m_wb_en);
            if (m_done) chk(wb_addr_o == m_wb_addr, "R7", "wb_addr", wb_addr_o, m_wb_addr);
            chk(pc_load_o == m_pc_load, "R9", "pc_load", pc_load_o, m_pc_load);
            if (m_pc_load) begin
                chk(pc_value_o == m_pc, "R9", "pc_value", pc_value_o, m_pc);
                chk(isa_sel_o == m_isa, "R9", "isa_sel", isa_sel_o, m_isa);
            end
            chk(restore_status_o == m_rst, "R10", "restore", restore_status_o, m_rst);
            chk(pc_in_list_o == m_pcflag, "R8", "pc_in_list", pc_in_list_o, m_pcflag);
        end
    end

    // ready and load data stimulus
    always @(negedge clk) begin
        xfer_ready_i <= rdy_rand ? 1'($urandom % 2) : 1'b1;
        rdata_i      <= $urandom;
    end

    task automatic run_op(input logic [31:0] base, input logic [15:0] list,
                          input logic [1:0] mode, input bit w, input bit ld,
                          input bit s, input bit hold, input string tag);
        @(negedge clk);
        xfer_cnt = 0;
        base_i = base; list_i = list; mode_i = mode;
        wback_i = w; load_i = ld; sbit_i = s; start_i = 1'b1;
        @(negedge clk);
        if (hold) begin
            list_i = ~list; base_i = base ^ 32'h0000_1000; mode_i = ~mode;
        end else begin
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        start_i = 1'b0;
        chk(xfer_cnt == $countones(list), tag, "transfer count", xfer_cnt, $countones(list));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14: reset state
        chk(!busy_o && !xfer_valid_o && !done_o, "R14", "busy/valid/done", {busy_o, xfer_valid_o, done_o}, 0);
        chk(!wb_en_o && !pc_load_o && !restore_status_o && !pc_in_list_o, "R14", "pulses",
            {wb_en_o, pc_load_o, restore_status_o, pc_in_list_o}, 0);
        rst_n = 1'b1;
        run_op(32'h0000_1000, 16'h0001, 2'b00, 1, 0, 0, 0, "R2");
        run_op(32'h0000_2000, 16'h8421, 2'b01, 1, 1, 0, 0, "R3");
        run_op(32'h0000_3000, 16'h00F0, 2'b10, 1, 0, 0, 0, "R4");
        run_op(32'h0000_4000, 16'hFFFF, 2'b11, 1, 1, 1, 0, "R5");
        run_op(32'h0000_0008, 16'h0F0F, 2'b11, 1, 0, 0, 0, "R5");
        run_op(32'h0000_5000, 16'h0000, 2'b01, 1, 0, 0, 0, "R11");
        run_op(32'h0000_6000, 16'h8000, 2'b00, 0, 1, 1, 0, "R10");
        run_op(32'h0000_7000, 16'h8003, 2'b10, 1, 0, 1, 0, "R9");
        rdy_rand = 1'b1;
        for (int k = 0; k < 40; k++) begin
            run_op($urandom, 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 0, "R12");
        end
        run_op(32'h0000_8000, 16'h0A05, 2'b00, 1, 1, 0, 1, "R13");
        run_op(32'hFFFF_FFF0, 16'hC001, 2'b01, 1, 1, 1, 1, "R13");
        rdy_rand = 1'b0;
        run_op(32'h0000_9000, 16'h0000, 2'b11, 0, 1, 1, 0, "R11");
        repeat (3) @(negedge clk);
        report();
    end
endmodule